// File: doc/BRIEF.md
# USB Endpoint Control and Data Toggle Tracker

This block holds the control state of one USB device endpoint. It covers the transmit (IN) direction and the receive (OUT) direction, and each direction has its own enable, stall, toggle-reset, toggle-inhibit and type controls. Software reaches these controls through a 32-bit read/write register. The transmit controls sit in the upper half of the register and the receive controls sit in the lower half. The block also tracks the DATA0/DATA1 data toggle for each direction.

The packet engine reports three events to the block:

- a SETUP request was received;
- the host acknowledged an IN data packet;
- an OUT data packet arrived, along with its PID.

The block returns the following for each direction:

- whether the direction is enabled;
- whether a STALL handshake must be sent;
- the data PID to send next, or the data PID expected next;
- a pulse that marks an event as taken.

A SETUP clears both stall bits. A toggle-reset write returns the toggle to DATA0. Packet coding, CRC and transaction scheduling are handled elsewhere. The type fields are only stored.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset, the register reads 0x0000_0000 and every per-direction output is 0.
- R2: Bit 23 enables transmit and bit 7 enables receive (1 means enabled). Each enable reads back as written and drives `en_o[1]` (transmit) and `en_o[0]` (receive) one cycle after the write.
- R3: The following bits always read 0 whatever is written: 31:24, 20, 17, 15:8, 4 and 1.
- R4: Bit 16 is the transmit stall and bit 0 is the receive stall. Each stall bit keeps its value until it is rewritten. `stall_o` for a direction is 1 while that direction's stall bit and enable bit are both set.
- R5: A SETUP event clears both stall bits on the next clock edge. This clear wins over a stall write in the same cycle.
- R6: Writing 1 to bit 22 (transmit) or bit 6 (receive) sets that direction's toggle to DATA0 (0). These bits always read 0. This works while the direction is disabled.
- R7: The transmit toggle, seen on `pid_o[1]`, flips after each IN acknowledge that arrives while transmit is enabled, not stalled and not inhibited. In that case `taken_o[1]` is 1.
- R8: An OUT packet on an enabled, unstalled receive direction behaves as follows:
  - If its PID (`out_pid_i`, 0 means DATA0) matches `pid_o[0]`, `taken_o[0]` is 1 in the same cycle and the toggle flips.
  - If its PID does not match, `taken_o[0]` is 0 and the toggle does not change.
- R9: Bit 21 (transmit) and bit 5 (receive) inhibit toggling for their direction. While inhibit is set:
  - `pid_o` for that direction is 0 (DATA0);
  - the toggle does not flip;
  - the receive direction takes an OUT packet whatever its PID.
- R10: A disabled or stalled direction ignores its data events: `taken_o` stays 0 and the toggle is unchanged. A disabled direction never raises `stall_o`.
- R11: Bits 19:18 (transmit) and bits 3:2 (receive) are type fields. They are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| setup_i | input | 1 | SETUP request received |
| in_ack_i | input | 1 | Host acknowledged an IN data packet |
| out_data_i | input | 1 | OUT data packet received |
| out_pid_i | input | 1 | PID of the OUT packet (0 = DATA0, 1 = DATA1) |
| en_o | output | 2 | Direction enabled ([1] transmit, [0] receive) |
| stall_o | output | 2 | Send a STALL handshake |
| pid_o | output | 2 | Next transmit PID ([1]) and expected receive PID ([0]) |
| taken_o | output | 2 | Data event taken this cycle |

## Verification
The bench drives a SETUP in the same cycle as a stall write. A design that gets this wrong leaves the endpoint stalled after the SETUP. It sends an OUT packet whose PID does not match the expected one. A design that flips on any OUT packet would break synchronisation with the host. It issues a toggle reset while the receive direction is disabled. A design that gates the reset with the enable keeps a stale DATA1. It writes all ones to the register. This exposes reserved bits that read back 1 and toggle-reset bits that do not clear themselves. It sends events to directions that are inhibited, disabled or stalled. A design that gates events wrongly either advances the toggle or fails to force DATA0.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned N_DIR    = 2;
  localparam int unsigned TYPE_W   = 2;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned RST_BIT  = 6;
  localparam int unsigned INH_BIT  = 5;
  localparam int unsigned TYPE_LSB = 2;
  localparam int unsigned STL_BIT  = 0;

  typedef struct packed {
    logic              en;
    logic              inh;
    logic [TYPE_W-1:0] typ;
    logic              stall;
  } dir_cfg_t;
endpackage

// File: rtl/ep_dir_ctrl.sv
module ep_dir_ctrl
  import usb_ep_pkg::*;
#(
  parameter bit CHK_PID = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [HALF_W-1:0] wfield_i,
  input  logic              setup_i,
  input  logic              evt_i,
  input  logic              evt_pid_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic              en_o,
  output logic              stall_o,
  output logic              pid_o,
  output logic              taken_o
);
  dir_cfg_t cfg_q, cfg_d;
  logic     tog_q, tog_d;
  logic     tog_clr, active, pid_ok;

  logic unused_wbits;
  assign unused_wbits = ^{wfield_i[HALF_W-1:EN_BIT+1], wfield_i[TYPE_LSB+TYPE_W],
                          wfield_i[STL_BIT+1]};

  assign tog_clr = wr_i & wfield_i[RST_BIT];
  assign active  = cfg_q.en & ~cfg_q.stall;
  assign pid_ok  = !CHK_PID || cfg_q.inh || (evt_pid_i == tog_q);
  assign taken_o = evt_i & active & pid_ok;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_i) begin
      cfg_d.en    = wfield_i[EN_BIT];
      cfg_d.inh   = wfield_i[INH_BIT];
      cfg_d.typ   = wfield_i[TYPE_LSB +: TYPE_W];
      cfg_d.stall = wfield_i[STL_BIT];
    end
    if (setup_i) cfg_d.stall = 1'b0;   // SETUP wins over a same-cycle write
  end

  always_comb begin
    tog_d = tog_q;
    if (tog_clr)                      tog_d = 1'b0;
    else if (taken_o && !cfg_q.inh)   tog_d = ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      tog_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      tog_q <= tog_d;
    end
  end

  always_comb begin
    rdata_o                       = '0;
    rdata_o[EN_BIT]               = cfg_q.en;
    rdata_o[INH_BIT]              = cfg_q.inh;
    rdata_o[TYPE_LSB +: TYPE_W]   = cfg_q.typ;
    rdata_o[STL_BIT]              = cfg_q.stall;
  end

  assign en_o    = cfg_q.en;
  assign stall_o = cfg_q.en & cfg_q.stall;
  assign pid_o   = cfg_q.inh ? 1'b0 : tog_q;

  p_setup_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i |=> !stall_o);
  p_tog_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tog_clr |=> !pid_o);
  p_flip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && !cfg_q.inh && !tog_clr) |=> (tog_q != $past(tog_q)));
  p_inh_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.inh && !tog_clr) |=> $stable(tog_q));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !tog_clr) |=> $stable(tog_q));
  p_dis_nostall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> !stall_o);
endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
  import usb_ep_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [2*HALF_W-1:0]   reg_wdata_i,
  output logic [2*HALF_W-1:0]   reg_rdata_o,
  input  logic                  setup_i,
  input  logic                  in_ack_i,
  input  logic                  out_data_i,
  input  logic                  out_pid_i,
  output logic [N_DIR-1:0]      en_o,
  output logic [N_DIR-1:0]      stall_o,
  output logic [N_DIR-1:0]      pid_o,
  output logic [N_DIR-1:0]      taken_o
);
  localparam int unsigned REG_W = N_DIR * HALF_W;

  logic [N_DIR-1:0] evt;
  assign evt = {in_ack_i, out_data_i};   // [1] transmit, [0] receive

  generate
    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
      ep_dir_ctrl #(
        .CHK_PID (g == 0)
      ) u_dir (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (reg_we_i),
        .wfield_i  (reg_wdata_i[g*HALF_W +: HALF_W]),
        .setup_i   (setup_i),
        .evt_i     (evt[g]),
        .evt_pid_i (out_pid_i),
        .rdata_o   (reg_rdata_o[g*HALF_W +: HALF_W]),
        .en_o      (en_o[g]),
        .stall_o   (stall_o[g]),
        .pid_o     (pid_o[g]),
        .taken_o   (taken_o[g])
      );
    end
  endgenerate

  p_resv_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[REG_W-1:24] == '0) && !reg_rdata_o[20] && !reg_rdata_o[17] &&
    (reg_rdata_o[15:8] == '0) && !reg_rdata_o[4] && !reg_rdata_o[1]);
  p_rst_bits_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[22] && !reg_rdata_o[6]);
  p_wr_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> (en_o == {$past(reg_wdata_i[23]), $past(reg_wdata_i[7])}));
endmodule

// File: tb/usb_ep_ctrl_bench.sv
module usb_ep_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  // {we, wdata, setup, in_ack, out_data, out_pid, exp_rdata, exp {en[1:0],stall[1:0],pid[1:0]}}
  localparam logic [74:0] VEC [NV] = '{
    {1'b1, 32'h0080_0080, 4'b0000, 32'h0080_0080, 6'b110000}, // R2 enable both
    {1'b0, 32'h0,         4'b0100, 32'h0080_0080, 6'b110010}, // R7 tx flip
    {1'b0, 32'h0,         4'b0100, 32'h0080_0080, 6'b110000}, // R7 tx flip back
    {1'b0, 32'h0,         4'b0010, 32'h0080_0080, 6'b110001}, // R8 match DATA0
    {1'b0, 32'h0,         4'b0010, 32'h0080_0080, 6'b110001}, // R8 mismatch held
    {1'b0, 32'h0,         4'b0011, 32'h0080_0080, 6'b110000}, // R8 match DATA1
    {1'b0, 32'h0,         4'b0100, 32'h0080_0080, 6'b110010}, // R7
    {1'b1, 32'h00C0_0080, 4'b0000, 32'h0080_0080, 6'b110000}, // R6 tx toggle reset
    {1'b1, 32'h0081_0081, 4'b0000, 32'h0081_0081, 6'b111100}, // R4 stall both
    {1'b0, 32'h0,         4'b0110, 32'h0081_0081, 6'b111100}, // R10 stalled ignores
    {1'b0, 32'h0,         4'b1000, 32'h0080_0080, 6'b110000}, // R5 setup clears
    {1'b1, 32'h0081_0081, 4'b1000, 32'h0080_0080, 6'b110000}, // R5 setup beats write
    {1'b1, 32'h00A0_00A0, 4'b0000, 32'h00A0_00A0, 6'b110000}, // R9 inhibit both
    {1'b0, 32'h0,         4'b0100, 32'h00A0_00A0, 6'b110000}, // R9 tx stays DATA0
    {1'b0, 32'h0,         4'b0011, 32'h00A0_00A0, 6'b110000}, // R9 rx no flip
    {1'b1, 32'h008C_000C, 4'b0000, 32'h008C_000C, 6'b100000}, // R11 types
    {1'b0, 32'h0,         4'b0010, 32'h008C_000C, 6'b100000}, // R10 rx disabled
    {1'b1, 32'h0000_0041, 4'b0000, 32'h0000_0001, 6'b000000}, // R10 stall hidden
    {1'b1, 32'hFFFF_FFFF, 4'b0000, 32'h00AD_00AD, 6'b111100}, // R3 reserved zero
    {1'b1, 32'h0000_0000, 4'b0000, 32'h0000_0000, 6'b000000}  // R2 disable
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        setup_i = 1'b0, in_ack_i = 1'b0, out_data_i = 1'b0, out_pid_i = 1'b0;
  logic [1:0]  en_o, stall_o, pid_o, taken_o;
  int total = 0, bad = 0;

  usb_ep_ctrl u_usb_ep_ctrl (
    .clk_i, .rst_ni, .reg_we_i, .reg_wdata_i, .reg_rdata_o, .setup_i,
    .in_ack_i, .out_data_i, .out_pid_i, .en_o, .stall_o, .pid_o, .taken_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [31:0] wd, input logic [3:0] ev);
    reg_we_i = we; reg_wdata_i = wd;
    {setup_i, in_ack_i, out_data_i, out_pid_i} = ev;
  endtask

  task automatic step(input logic we, input logic [31:0] wd, input logic [3:0] ev);
    drive(we, wd, ev);
    @(posedge clk_i);
    @(negedge clk_i);
    drive(1'b0, 32'h0, 4'b0000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1 rdata", 64'(reg_rdata_o), 64'h0);
    check("R1 outs", 64'({en_o, stall_o, pid_o, taken_o}), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][74], VEC[i][73:42], VEC[i][41:38]);
      check($sformatf("vec%0d rdata", i), 64'(reg_rdata_o), 64'(VEC[i][37:6]));
      check($sformatf("vec%0d outs", i), 64'({en_o, stall_o, pid_o}), 64'(VEC[i][5:0]));
    end

    // R8: same-cycle take on match, refusal on mismatch
    step(1'b1, 32'h0000_0080, 4'b0000);
    drive(1'b0, 32'h0, 4'b0010);
    #1 check("R8 take match", 64'(taken_o), 64'h1);
    @(posedge clk_i); @(negedge clk_i);
    drive(1'b0, 32'h0, 4'b0010);
    #1 check("R8 refuse mismatch", 64'(taken_o), 64'h0);
    @(posedge clk_i); @(negedge clk_i);
    check("R8 toggle held", 64'(pid_o), 64'h1);
    // R7: IN ack taken on tx only when enabled
    drive(1'b0, 32'h0, 4'b0100);
    #1 check("R10 tx disabled no take", 64'(taken_o), 64'h0);
    @(posedge clk_i); @(negedge clk_i);
    // R6: toggle reset on disabled rx
    step(1'b1, 32'h0000_0000, 4'b0000);
    check("R6 held while disabled", 64'(pid_o), 64'h1);
    step(1'b1, 32'h0000_0040, 4'b0000);
    check("R6 reset while disabled", 64'(pid_o), 64'h0);
    check("R6 reads 0", 64'(reg_rdata_o), 64'h0);
    // R9: inhibited rx takes any PID
    step(1'b1, 32'h0000_00A0, 4'b0000);
    drive(1'b0, 32'h0, 4'b0011);
    #1 check("R9 inhibit take any", 64'(taken_o), 64'h1);
    @(posedge clk_i); @(negedge clk_i);
    drive(1'b0, 32'h0, 4'b0000);
    // R1: reset mid-run
    step(1'b1, 32'h0081_0081, 4'b0000);
    rst_ni = 1'b0;
    #1 check("R1 reset again", 64'({reg_rdata_o, en_o, stall_o, pid_o}), 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule